// File: doc/BRIEF.md
# Bit-Serial Arithmetic and Compare Unit

This block is the arithmetic heart of a core whose datapath is one bit wide. Each cycle it takes one bit of the first operand, which comes from the first source register stream, and one bit of the second operand. The second operand comes either from the second source register stream or from the immediate stream. Bits arrive least significant first, and a 32-bit word takes 32 enabled cycles. The result bit leaves in the same cycle, so a register file can write it back at once. Carry, equality and ordering state live in flip-flops between bits.

A compare flag reports equality or less-than, signed or unsigned, once the last bit of a stage has been seen. Branch logic uses it to decide whether a branch is taken. A second pass in set-less-than mode turns that flag into a full result word.

The caller supplies a bit counter with an enable. The unit treats count 0 as the first bit and count WIDTH-1 as the last. While enable is low, nothing in the unit changes.

Top module: `serial_alu`

## Requirements
- R1: When `useImm` is 1, operand B is `immBit`. Otherwise operand B is `rs2Bit`. The unused stream has no effect on the result.
- R2: With `resSel` = 00 and `subMode` = 0, the serial result over one stage equals the 32-bit sum A+B modulo 2^32. The carry starts at 0 on the count-0 bit.
- R3: With `resSel` = 00 and `subMode` = 1, the result equals A + ~B + 1, which is A-B modulo 2^32. The carry is preset to 1 on the count-0 bit.
- R4: Cycles with `enable` = 0 may fall between bits of a stage. They leave the carry and the flags unchanged, whatever the data inputs carry.
- R5: After a stage with `subMode` = 1, the flag for `cmpEq` = 1 is 1 exactly when A equals B.
- R6: After a stage with `subMode` = 1 and `cmpSigned` = 1, the flag for `cmpEq` = 0 is 1 exactly when A < B as two's-complement numbers.
- R7: After a stage with `subMode` = 1 and `cmpSigned` = 0, the flag for `cmpEq` = 0 is 1 exactly when A < B as unsigned numbers.
- R8: With `resSel` = 01, each result bit is a boolean function of the current A and B bits. `boolCode` 00 or 01 gives XOR, 10 gives OR, and 11 gives AND.
- R9: With `resSel` = 10, the result is the stored less-than flag on the count-0 bit and 0 on every other bit. This pass leaves the carry and the flags unchanged.
- R10: Reset (`rstN` low, synchronous) sets the equality flag to 1, the less-than flag to 0 and the carry to 0.
- R11: `cmpFlag` changes only through `cmpEq` or on the count-(WIDTH-1) bit of an arithmetic or boolean stage. It holds its value through idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| enable | input | 1 | A bit is processed this cycle |
| cnt | input | CNT_W | Index of the current bit within the stage |
| rs1Bit | input | 1 | Serial operand A bit |
| rs2Bit | input | 1 | Serial register operand B bit |
| immBit | input | 1 | Serial immediate operand B bit |
| useImm | input | 1 | 1 selects the immediate as operand B |
| subMode | input | 1 | 1 selects subtraction and compare mode |
| resSel | input | 2 | Result source: 00/11 arithmetic, 01 boolean, 10 set-less-than |
| boolCode | input | 2 | Boolean function: 0x XOR, 10 OR, 11 AND |
| cmpSigned | input | 1 | 1 selects a signed less-than |
| cmpEq | input | 1 | 1 makes cmpFlag report equality, 0 less-than |
| resBit | output | 1 | Serial result bit, valid in the same cycle |
| cmpFlag | output | 1 | Compare result from the last completed stage |

## Verification
Each operand pair in the table runs through add, subtract with signed and unsigned compare, a set-less-than pass and all three boolean codes. The pairs are chosen to separate specific faults. Pairs with equal operands separate the equality flag from the less-than flag. Pairs that mix signs, such as 0x80000000 against 0x7FFFFFFF, make the signed and unsigned verdicts disagree and so expose a swapped sign rule. A pair of all-ones plus one carries through every bit, which catches a carry that is lost or misseeded. The register stream and the immediate stream always carry complementary data, so a wrong operand select corrupts every result. Stages with idle cycles inserted between bits show whether stalled cycles disturb the carry.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;

  typedef enum logic [1:0] {
    RES_ARITH  = 2'b00,
    RES_BOOL   = 2'b01,
    RES_SETLT  = 2'b10,
    RES_ARITH2 = 2'b11
  } resSel_e;

  typedef struct packed {
    logic firstBit;   // enabled bit at count 0
    logic lastBit;    // enabled bit at the final count
    logic stepEn;     // carry and flags may advance
    logic carrySeed;  // carry value injected on the first bit
  } aluStrobe_t;

endpackage

// File: rtl/serial_alu_ctrl.sv
module serial_alu_ctrl
  import serial_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH)
) (
  input  logic             enable,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       resSel,
  input  logic             subMode,
  output aluStrobe_t       stb
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

  resSel_e selMode;

  always_comb begin
    selMode       = resSel_e'(resSel);
    stb.firstBit  = enable && (cnt == '0);
    stb.lastBit   = enable && (cnt == LAST_IDX);
    stb.stepEn    = enable && (selMode != RES_SETLT);
    stb.carrySeed = subMode;
  end
endmodule

// File: rtl/serial_alu_dp.sv
module serial_alu_dp
  import serial_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  aluStrobe_t stb,
  input  logic       rs1Bit,
  input  logic       rs2Bit,
  input  logic       immBit,
  input  logic       useImm,
  input  logic       subMode,
  input  logic [1:0] resSel,
  input  logic [1:0] boolCode,
  input  logic       cmpSigned,
  input  logic       cmpEq,
  output logic       resBit,
  output logic       cmpFlag
);
  logic carryQ, eqQ, ltQ;
  logic opB, bEff, carryIn, sumBit, carryOut;
  logic eqNext, ltSignedNow, ltUnsignedNow;
  logic boolBit, setLtBit;
  resSel_e selMode;

  always_comb begin
    opB      = useImm ? immBit : rs2Bit;
    bEff     = opB ^ subMode;
    carryIn  = stb.firstBit ? stb.carrySeed : carryQ;
    sumBit   = rs1Bit ^ bEff ^ carryIn;
    carryOut = (rs1Bit & bEff) | (carryIn & (rs1Bit ^ bEff));

    eqNext        = (stb.firstBit ? 1'b1 : eqQ) & ~sumBit;
    ltSignedNow   = (rs1Bit & ~opB) | (~(rs1Bit ^ opB) & sumBit);
    ltUnsignedNow = ~carryOut;

    unique case (boolCode)
      2'b10:   boolBit = rs1Bit | opB;
      2'b11:   boolBit = rs1Bit & opB;
      default: boolBit = rs1Bit ^ opB;
    endcase

    setLtBit = stb.firstBit ? ltQ : 1'b0;

    selMode = resSel_e'(resSel);
    unique case (selMode)
      RES_BOOL:  resBit = boolBit;
      RES_SETLT: resBit = setLtBit;
      default:   resBit = sumBit;
    endcase

    cmpFlag = cmpEq ? eqQ : ltQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryQ <= 1'b0;
      eqQ    <= 1'b1;
      ltQ    <= 1'b0;
    end else if (stb.stepEn) begin
      carryQ <= carryOut;
      eqQ    <= eqNext;
      if (stb.lastBit) ltQ <= cmpSigned ? ltSignedNow : ltUnsignedNow;
    end
  end
endmodule

// File: rtl/serial_alu.sv
module serial_alu
  import serial_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] cnt,
  input  logic             rs1Bit,
  input  logic             rs2Bit,
  input  logic             immBit,
  input  logic             useImm,
  input  logic             subMode,
  input  logic [1:0]       resSel,
  input  logic [1:0]       boolCode,
  input  logic             cmpSigned,
  input  logic             cmpEq,
  output logic             resBit,
  output logic             cmpFlag
);
  aluStrobe_t stb;

  serial_alu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .enable (enable),
    .cnt    (cnt),
    .resSel (resSel),
    .subMode(subMode),
    .stb    (stb)
  );

  serial_alu_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rs1Bit   (rs1Bit),
    .rs2Bit   (rs2Bit),
    .immBit   (immBit),
    .useImm   (useImm),
    .subMode  (subMode),
    .resSel   (resSel),
    .boolCode (boolCode),
    .cmpSigned(cmpSigned),
    .cmpEq    (cmpEq),
    .resBit   (resBit),
    .cmpFlag  (cmpFlag)
  );
endmodule

// File: rtl/serial_alu_chk.sv
module serial_alu_chk #(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [CNT_W-1:0] cnt,
  input logic             rs1Bit,
  input logic             rs2Bit,
  input logic             immBit,
  input logic             useImm,
  input logic             subMode,
  input logic [1:0]       resSel,
  input logic [1:0]       boolCode,
  input logic             cmpSigned,
  input logic             cmpEq,
  input logic             resBit,
  input logic             cmpFlag
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

  // R1: immediate chosen as operand B
  a_r1_imm_select: assert property (@(posedge clk) disable iff (!rstN)
    (enable && resSel == 2'b01 && boolCode == 2'b00 && useImm) |-> (resBit == (rs1Bit ^ immBit)));

  // R2: first bit of an add has no incoming carry
  a_r2_first_add: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cnt == '0 && resSel == 2'b00 && !subMode) |->
      (resBit == (rs1Bit ^ (useImm ? immBit : rs2Bit))));

  // R5: any nonzero difference bit kills equality
  a_r5_eq_clears: assert property (@(posedge clk) disable iff (!rstN)
    (enable && resSel != 2'b10 && subMode && resBit) |=> (!cmpEq || !cmpFlag));

  // R8: AND with a zero A bit is zero
  a_r8_and_zero: assert property (@(posedge clk) disable iff (!rstN)
    (resSel == 2'b01 && boolCode == 2'b11 && !rs1Bit) |-> !resBit);

  // R9: set-less-than pass emits zeros above bit 0
  a_r9_setlt_upper: assert property (@(posedge clk) disable iff (!rstN)
    (enable && resSel == 2'b10 && cnt != '0) |-> !resBit);

  // R11: less-than view holds outside the final arithmetic bit
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmpEq && !(enable && cnt == LAST_IDX && resSel != 2'b10)) |=> (cmpEq || $stable(cmpFlag)));

  // R4: idle cycles do not move the less-than view
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !cmpEq) |=> (cmpEq || $stable(cmpFlag)));
endmodule

bind serial_alu serial_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/serial_alu_test.sv
`timescale 1ns/1ps
module serial_alu_test;
  localparam int WIDTH = 32;
  localparam int CNT_W = $clog2(WIDTH);
  localparam int NVEC  = 8;

  // {a, b, useImm}
  localparam logic [64:0] VECS [NVEC] = '{
    {32'd5,          32'd3,          1'b0},
    {32'd3,          32'd5,          1'b1},
    {32'hFFFF_FFFF,  32'd1,          1'b0},
    {32'h8000_0000,  32'h7FFF_FFFF,  1'b1},
    {32'h7FFF_FFFF,  32'h8000_0000,  1'b0},
    {32'h1234_5678,  32'h1234_5678,  1'b1},
    {32'd0,          32'd0,          1'b0},
    {32'hDEAD_BEEF,  32'h0F0F_00FF,  1'b1}
  };

  logic clk = 1'b0;
  logic rstN, enable, rs1Bit, rs2Bit, immBit, useImm, subMode, cmpSigned, cmpEq;
  logic [CNT_W-1:0] cnt;
  logic [1:0] resSel, boolCode;
  logic resBit, cmpFlag;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  serial_alu #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .cnt(cnt),
    .rs1Bit(rs1Bit), .rs2Bit(rs2Bit), .immBit(immBit), .useImm(useImm),
    .subMode(subMode), .resSel(resSel), .boolCode(boolCode),
    .cmpSigned(cmpSigned), .cmpEq(cmpEq), .resBit(resBit), .cmpFlag(cmpFlag)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runStage(input logic [31:0] a, input logic [31:0] b, input logic imm,
                          input logic [1:0] sel, input logic sub, input logic [1:0] bc,
                          input logic sgn, input logic gap, output logic [31:0] res);
    res = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (gap && (i % 7 == 3)) begin
        @(negedge clk);
        enable = 1'b0; cnt = '0; rs1Bit = 1'b1; rs2Bit = 1'b1; immBit = 1'b1;
        subMode = ~sub; resSel = 2'b00;
      end
      @(negedge clk);
      enable = 1'b1; cnt = CNT_W'(i);
      useImm = imm; subMode = sub; resSel = sel; boolCode = bc; cmpSigned = sgn;
      rs1Bit = a[i];
      rs2Bit = imm ? ~b[i] : b[i];
      immBit = imm ? b[i] : ~b[i];
      #1 res[i] = resBit;
    end
    @(negedge clk);
    enable = 1'b0;
    #1;
  endtask

  task automatic flagIs(input logic eqSel, input logic exp, input string req);
    cmpEq = eqSel;
    #1 check(cmpFlag === exp, req, {31'b0, cmpFlag}, {31'b0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] res;
    rstN = 1'b0; enable = 1'b0; cnt = '0; rs1Bit = 0; rs2Bit = 0; immBit = 0;
    useImm = 0; subMode = 0; resSel = 2'b00; boolCode = 2'b00; cmpSigned = 0; cmpEq = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: reset state of both flags
    flagIs(1'b1, 1'b1, "R10 eq after reset");
    flagIs(1'b0, 1'b0, "R10 lt after reset");

    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] a, b;
      logic im, ltS, ltU;
      a = VECS[v][64:33]; b = VECS[v][32:1]; im = VECS[v][0];
      ltS = $signed(a) < $signed(b);
      ltU = a < b;
      runStage(a, b, im, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, res);
      check(res == a + b, "R2 add (R1 operand select)", res, a + b);
      runStage(a, b, im, 2'b00, 1'b1, 2'b00, 1'b1, 1'b0, res);
      check(res == a - b, "R3 subtract", res, a - b);
      flagIs(1'b1, a == b, "R5 equality");
      flagIs(1'b0, ltS, "R6 signed less-than");
      runStage(a, b, im, 2'b10, 1'b0, 2'b00, 1'b0, 1'b0, res);
      check(res == {31'b0, ltS}, "R9 set-less-than pass", res, {31'b0, ltS});
      flagIs(1'b0, ltS, "R9 flags untouched by pass");
      runStage(a, b, im, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0, res);
      flagIs(1'b0, ltU, "R7 unsigned less-than");
      runStage(a, b, im, 2'b01, 1'b0, 2'b00, 1'b0, 1'b0, res);
      check(res == (a ^ b), "R8 xor", res, a ^ b);
      runStage(a, b, im, 2'b01, 1'b0, 2'b10, 1'b0, 1'b0, res);
      check(res == (a | b), "R8 or", res, a | b);
      runStage(a, b, im, 2'b01, 1'b0, 2'b11, 1'b0, 1'b0, res);
      check(res == (a & b), "R8 and", res, a & b);
    end

    // R4: idle gaps inside add and subtract stages
    runStage(32'hFFFF_FFFF, 32'd1, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 1'b1, res);
    check(res == 32'd0, "R4 add with idle gaps", res, 32'd0);
    runStage(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 2'b00, 1'b1, 2'b00, 1'b0, 1'b1, res);
    check(res == 32'h0000_0001, "R4 subtract with idle gaps", res, 32'h0000_0001);
    flagIs(1'b0, 1'b0, "R4 unsigned flag after gaps");

    // R11: flag holds through idle cycles with busy data lines
    runStage(32'd3, 32'd9, 1'b0, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0, res);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      rs1Bit = k[0]; rs2Bit = k[1]; immBit = k[2]; cnt = CNT_W'(WIDTH - 1); subMode = k[0];
    end
    flagIs(1'b0, 1'b1, "R11 lt held through idle");
    flagIs(1'b1, 1'b0, "R11 eq held through idle");

    // R10: reset in the middle of operation
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    flagIs(1'b0, 1'b0, "R10 lt cleared by reset");
    flagIs(1'b1, 1'b1, "R10 eq restored by reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule